// File: doc/BRIEF.md
# Host/DSP Mailbox Controller

This block is a small shared register file through which a host processor and a DSP exchange 16-bit messages. Two inbound message registers carry words from the host to the DSP, and two outbound message registers carry words the other way. An 8-bit event register records which mailboxes have been filled, drained or released. An 8-bit enable register chooses which of those events drive the DSP interrupt and the host interrupt.

Each side has its own synchronous register port with an address, write and read strobes, write data and registered read data. The host's reads never change state. For that reason the host frees an outbound mailbox by writing a one to that mailbox's event bit. That write-one clear is recorded as a separate release event, which the DSP can take as an interrupt. When the DSP reads an inbound mailbox, the read itself is recorded as an event, which the host can take as an interrupt.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset, all four mailboxes, the event register, the enable register, both read-data outputs and both interrupt outputs are zero.
- R2: Word offsets are 0x20 event, 0x22 enable, 0x24 inbound 0, 0x26 inbound 1, 0x28 outbound 0 and 0x2A outbound 1. Address bit 0 is ignored. Either port may read or write any mailbox. Read data appears on that port's read-data output one cycle after its read strobe. Reads of any other address return zero.
- R3: A host write to inbound mailbox n (n = 0 or 1) sets event bit n.
- R4: A DSP read of inbound mailbox n sets event bit 2+n.
- R5: A DSP write to outbound mailbox n sets event bit 4+n, the valid flag of that mailbox.
- R6: A host read of any address changes no register in the block.
- R7: Event bits clear when a one is written to them from either port, and writing a zero leaves them unchanged. The enable register is plain read/write in bits 7:0, and bits 15:8 read as zero.
- R8: A host write-one to event bit 4+n while that bit is set also sets event bit 6+n, the release flag of that mailbox. A DSP write-one only clears the bit.
- R9: When an event and a write-one clear hit the same event bit in one cycle, the bit ends up set.
- R10: When both ports write the same mailbox or the enable register in one cycle, the DSP's data is kept.
- R11: dsp_irq is the OR of event bits 0, 1, 6 and 7, each masked by the enable bit at the same position. host_irq is the same for bits 2 to 5. Both are registered and follow the event and enable registers one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 8 | Host byte address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, registered |
| d_addr | input | 8 | DSP byte address |
| d_wr | input | 1 | DSP write strobe |
| d_rd | input | 1 | DSP read strobe |
| d_wdata | input | 16 | DSP write data |
| d_rdata | output | 16 | DSP read data, registered |
| dsp_irq | output | 1 | Interrupt toward the DSP |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
Data words go both ways, and one outbound read uses an odd address, which tests that address bit 0 is ignored. Event handling is driven by separate host and DSP accesses so that each event bit can be traced to the action that set it. A host read is repeated on a filled outbox to show that host reads leave state unchanged. Clears are written both as zeros and as ones, to tell a true write-one clear from a plain write. Same-cycle collisions are driven as a set against a clear and as a host write against a DSP write, which shows which source wins. The interrupts are sampled just before and just after their one-cycle delay, and once with the matching enable bit off, so that the masking and the timing are each checked.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int STAT_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_CTRL, SEL_IN0, SEL_IN1, SEL_OUT0, SEL_OUT1
  } reg_sel_e;

  localparam logic [7:0] OFS_STAT = 8'h20;
  localparam logic [7:0] OFS_CTRL = 8'h22;
  localparam logic [7:0] OFS_IN0  = 8'h24;
  localparam logic [7:0] OFS_IN1  = 8'h26;
  localparam logic [7:0] OFS_OUT0 = 8'h28;
  localparam logic [7:0] OFS_OUT1 = 8'h2A;

  // events routed to each interrupt
  localparam logic [STAT_W-1:0] DSP_IRQ_MASK  = 8'hC3;
  localparam logic [STAT_W-1:0] HOST_IRQ_MASK = 8'h3C;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);

  logic [ADDR_W-1:0] word;

  always_comb begin
    word = addr & EVEN_MASK;
    if      (word == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (word == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
    else if (word == ADDR_W'(OFS_IN0))  sel = SEL_IN0;
    else if (word == ADDR_W'(OFS_IN1))  sel = SEL_IN1;
    else if (word == ADDR_W'(OFS_OUT0)) sel = SEL_OUT0;
    else if (word == ADDR_W'(OFS_OUT1)) sel = SEL_OUT1;
    else                                sel = SEL_NONE;
  end
endmodule

// File: rtl/mbox_datafile.sv
module mbox_datafile #(
  parameter int DATA_W  = 16,
  parameter int NUM_BOX = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_BOX-1:0]             h_we,
  input  logic [NUM_BOX-1:0]             d_we,
  input  logic [DATA_W-1:0]              h_wdata,
  input  logic [DATA_W-1:0]              d_wdata,
  output logic [NUM_BOX-1:0][DATA_W-1:0] box_q
);
  for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
    logic              ce;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] q;

    always_comb begin
      ce  = h_we[b] | d_we[b];
      nxt = d_we[b] ? d_wdata : h_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ce) q <= nxt;
    end

    assign box_q[b] = q;

    AST_DSP_WINS_BOX: assert property (@(posedge clk) disable iff (!rst_n)
      (h_we[b] && d_we[b]) |=> (q == $past(d_wdata))); // R10
  end
endmodule

// File: rtl/mbox_status.sv
module mbox_status
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_evt,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic              en_we,
  input  logic [STAT_W-1:0] en_wdata,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] en_q,
  output logic              dsp_irq,
  output logic              host_irq
);
  logic [STAT_W-1:0] stat_d;
  logic [STAT_W-1:0] en_d;
  logic              dsp_irq_d;
  logic              host_irq_d;

  always_comb begin
    stat_d     = (stat_q & ~clr_mask) | set_evt;
    en_d       = en_we ? en_wdata : en_q;
    dsp_irq_d  = |(stat_q & en_q & DSP_IRQ_MASK);
    host_irq_d = |(stat_q & en_q & HOST_IRQ_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      en_q     <= '0;
      dsp_irq  <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      stat_q   <= stat_d;
      en_q     <= en_d;
      dsp_irq  <= dsp_irq_d;
      host_irq <= host_irq_d;
    end
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_evt & clr_mask)) |=> ((stat_q & $past(set_evt)) == $past(set_evt))); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_evt)) |=> ((stat_q & $past(clr_mask & ~set_evt)) == '0)); // R7
  AST_DSP_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsp_irq) |-> $past(|(stat_q & en_q & DSP_IRQ_MASK))); // R11
  AST_HOST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(|(stat_q & en_q & HOST_IRQ_MASK))); // R11
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic              d_wr,
  input  logic              d_rd,
  input  logic [DATA_W-1:0] d_wdata,
  output logic [DATA_W-1:0] d_rdata,
  output logic              dsp_irq,
  output logic              host_irq
);
  localparam int NUM_BOX = 4;

  reg_sel_e                    h_sel, d_sel;
  logic [NUM_BOX-1:0]          h_we_box, d_we_box;
  logic [NUM_BOX-1:0][DATA_W-1:0] box_q;
  logic [STAT_W-1:0]           stat_q, en_q, set_evt, h_clr, d_clr, clr_mask, en_wdata;
  logic                        en_we;
  logic [DATA_W-1:0]           h_rmux, d_rmux, h_rdata_d, d_rdata_d;

  mbox_decode #(.ADDR_W(ADDR_W)) u_hdec (.addr(h_addr), .sel(h_sel));
  mbox_decode #(.ADDR_W(ADDR_W)) u_ddec (.addr(d_addr), .sel(d_sel));

  // write strobes and event generation
  always_comb begin
    h_we_box = {h_wr && (h_sel == SEL_OUT1), h_wr && (h_sel == SEL_OUT0),
                h_wr && (h_sel == SEL_IN1),  h_wr && (h_sel == SEL_IN0)};
    d_we_box = {d_wr && (d_sel == SEL_OUT1), d_wr && (d_sel == SEL_OUT0),
                d_wr && (d_sel == SEL_IN1),  d_wr && (d_sel == SEL_IN0)};
    h_clr    = (h_wr && (h_sel == SEL_STAT)) ? h_wdata[STAT_W-1:0] : '0;
    d_clr    = (d_wr && (d_sel == SEL_STAT)) ? d_wdata[STAT_W-1:0] : '0;
    clr_mask = h_clr | d_clr;
    set_evt  = {h_clr[5] & stat_q[5], h_clr[4] & stat_q[4],
                d_we_box[3], d_we_box[2],
                d_rd && (d_sel == SEL_IN1), d_rd && (d_sel == SEL_IN0),
                h_we_box[1], h_we_box[0]};
    en_we    = (h_wr && (h_sel == SEL_CTRL)) || (d_wr && (d_sel == SEL_CTRL));
    en_wdata = (d_wr && (d_sel == SEL_CTRL)) ? d_wdata[STAT_W-1:0] : h_wdata[STAT_W-1:0];
  end

  mbox_datafile #(.DATA_W(DATA_W), .NUM_BOX(NUM_BOX)) u_data (
    .clk(clk), .rst_n(rst_n), .h_we(h_we_box), .d_we(d_we_box),
    .h_wdata(h_wdata), .d_wdata(d_wdata), .box_q(box_q)
  );

  mbox_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_mask(clr_mask),
    .en_we(en_we), .en_wdata(en_wdata), .stat_q(stat_q), .en_q(en_q),
    .dsp_irq(dsp_irq), .host_irq(host_irq)
  );

  // read-back selection
  always_comb begin
    unique case (h_sel)
      SEL_STAT: h_rmux = DATA_W'(stat_q);
      SEL_CTRL: h_rmux = DATA_W'(en_q);
      SEL_IN0:  h_rmux = box_q[0];
      SEL_IN1:  h_rmux = box_q[1];
      SEL_OUT0: h_rmux = box_q[2];
      SEL_OUT1: h_rmux = box_q[3];
      default:  h_rmux = '0;
    endcase
    unique case (d_sel)
      SEL_STAT: d_rmux = DATA_W'(stat_q);
      SEL_CTRL: d_rmux = DATA_W'(en_q);
      SEL_IN0:  d_rmux = box_q[0];
      SEL_IN1:  d_rmux = box_q[1];
      SEL_OUT0: d_rmux = box_q[2];
      SEL_OUT1: d_rmux = box_q[3];
      default:  d_rmux = '0;
    endcase
    h_rdata_d = h_rd ? h_rmux : h_rdata;
    d_rdata_d = d_rd ? d_rmux : d_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rdata <= '0;
      d_rdata <= '0;
    end else begin
      h_rdata <= h_rdata_d;
      d_rdata <= d_rdata_d;
    end
  end

  AST_HOST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_wr && !d_wr && !d_rd) |=> ($stable(stat_q) && $stable(box_q) && $stable(en_q))); // R6
  AST_INBOX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && (h_sel == SEL_IN0)) |=> stat_q[0]); // R3
  AST_OUTBOX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr && (d_sel == SEL_OUT1)) |=> stat_q[5]); // R5
  AST_DRAIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rd && (d_sel == SEL_IN1)) |=> stat_q[3]); // R4
endmodule

// File: tb/mbox_ctrl_tb.sv
module mbox_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  h_addr, d_addr;
  logic        h_wr, h_rd, d_wr, d_rd;
  logic [15:0] h_wdata, d_wdata;
  logic [15:0] h_rdata, d_rdata;
  logic        dsp_irq, host_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .d_addr(d_addr), .d_wr(d_wr), .d_rd(d_rd), .d_wdata(d_wdata), .d_rdata(d_rdata),
    .dsp_irq(dsp_irq), .host_irq(host_irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock with the given strobes; returns at the following falling edge
  task automatic cyc(logic hw, logic hr, logic [7:0] ha, logic [15:0] hd,
                     logic dw, logic dr, logic [7:0] da, logic [15:0] dd);
    @(negedge clk);
    h_wr = hw; h_rd = hr; h_addr = ha; h_wdata = hd;
    d_wr = dw; d_rd = dr; d_addr = da; d_wdata = dd;
    @(posedge clk);
    @(negedge clk);
    h_wr = 0; h_rd = 0; d_wr = 0; d_rd = 0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic hwr(logic [7:0] a, logic [15:0] v); cyc(1, 0, a, v, 0, 0, 8'h0, 16'h0); endtask
  task automatic dwr(logic [7:0] a, logic [15:0] v); cyc(0, 0, 8'h0, 16'h0, 1, 0, a, v); endtask
  task automatic hrd(logic [7:0] a, output logic [15:0] v);
    cyc(0, 1, a, 16'h0, 0, 0, 8'h0, 16'h0); v = h_rdata;
  endtask
  task automatic drd(logic [7:0] a, output logic [15:0] v);
    cyc(0, 0, 8'h0, 16'h0, 0, 1, a, 16'h0); v = d_rdata;
  endtask

  task automatic clean();
    dwr(8'h20, 16'h00FF);
    dwr(8'h22, 16'h0000);
    idle();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 h_rdata", h_rdata, 16'h0);
    check("R1 d_rdata", d_rdata, 16'h0);
    check("R1 dsp_irq", {15'h0, dsp_irq}, 16'h0);
    check("R1 host_irq", {15'h0, host_irq}, 16'h0);
    hrd(8'h20, v); check("R1 status", v, 16'h0);
    hrd(8'h22, v); check("R1 enable", v, 16'h0);
    hrd(8'h2A, v); check("R1 outbox1", v, 16'h0);
  endtask

  task automatic t_data();
    logic [15:0] v;
    clean();
    hwr(8'h24, 16'h1234);
    drd(8'h24, v); check("R2 inbox0 host->dsp", v, 16'h1234);
    dwr(8'h2A, 16'hBEEF);
    hrd(8'h2B, v); check("R2 outbox1 odd addr", v, 16'hBEEF);
    dwr(8'h26, 16'h5A5A);
    hrd(8'h26, v); check("R2 inbox1 dsp write", v, 16'h5A5A);
    hrd(8'h30, v); check("R2 unmapped read", v, 16'h0);
  endtask

  task automatic t_inbox_events();
    logic [15:0] v;
    clean();
    hwr(8'h26, 16'h0005);
    drd(8'h20, v); check("R3 host write inbox1", v, 16'h0002);
    drd(8'h26, v); check("R4 dsp read data", v, 16'h0005);
    drd(8'h20, v); check("R4 dsp read inbox1", v, 16'h000A);
    hwr(8'h24, 16'h0007);
    drd(8'h24, v);
    drd(8'h20, v); check("R3 R4 inbox0 events", v, 16'h000F);
  endtask

  task automatic t_outbox_release();
    logic [15:0] v;
    clean();
    dwr(8'h28, 16'hC0DE);
    hrd(8'h20, v); check("R5 outbox0 valid", v, 16'h0010);
    hrd(8'h28, v); check("R6 host read data", v, 16'hC0DE);
    hrd(8'h28, v);
    hrd(8'h20, v); check("R6 host read no effect", v, 16'h0010);
    hwr(8'h20, 16'h0000);
    hrd(8'h20, v); check("R7 write zero keeps", v, 16'h0010);
    hwr(8'h20, 16'h0010);
    hrd(8'h20, v); check("R8 host release", v, 16'h0040);
    hwr(8'h20, 16'h0040);
    hrd(8'h20, v); check("R7 w1c clears", v, 16'h0000);
    dwr(8'h2A, 16'h0001);
    dwr(8'h20, 16'h0020);
    hrd(8'h20, v); check("R8 dsp clear no release", v, 16'h0000);
    hwr(8'h22, 16'h01A5);
    drd(8'h22, v); check("R7 enable rw width", v, 16'h00A5);
  endtask

  task automatic t_collisions();
    logic [15:0] v;
    clean();
    dwr(8'h28, 16'h0001);
    cyc(1, 0, 8'h20, 16'h0010, 1, 0, 8'h28, 16'h0002);
    hrd(8'h20, v); check("R9 set beats clear", v, 16'h0050);
    cyc(1, 0, 8'h24, 16'h1111, 1, 0, 8'h24, 16'h2222);
    hrd(8'h24, v); check("R10 dsp wins inbox0", v, 16'h2222);
    cyc(1, 0, 8'h22, 16'h000F, 1, 0, 8'h22, 16'h00F0);
    hrd(8'h22, v); check("R10 dsp wins enable", v, 16'h00F0);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    clean();
    hwr(8'h24, 16'h0001);
    idle();
    check("R11 masked dsp_irq", {15'h0, dsp_irq}, 16'h0);
    dwr(8'h22, 16'h0001);
    check("R11 dsp_irq delay", {15'h0, dsp_irq}, 16'h0);
    idle();
    check("R11 dsp_irq inbox0", {15'h0, dsp_irq}, 16'h1);
    check("R11 host_irq quiet", {15'h0, host_irq}, 16'h0);
    dwr(8'h20, 16'h0001);
    idle();
    check("R11 dsp_irq cleared", {15'h0, dsp_irq}, 16'h0);
    dwr(8'h22, 16'h0004);
    drd(8'h24, v);
    idle();
    check("R11 host_irq drain", {15'h0, host_irq}, 16'h1);
    clean();
    dwr(8'h22, 16'h0040);
    dwr(8'h28, 16'h0009);
    hwr(8'h20, 16'h0010);
    idle();
    check("R11 dsp_irq release", {15'h0, dsp_irq}, 16'h1);
    check("R11 host_irq masked", {15'h0, host_irq}, 16'h0);
  endtask

  initial begin
    rst_n = 0;
    h_wr = 0; h_rd = 0; h_addr = '0; h_wdata = '0;
    d_wr = 0; d_rd = 0; d_addr = '0; d_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_data();
    t_inbox_events();
    t_outbox_release();
    t_collisions();
    t_irq();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule